// File: doc/BRIEF.md
# Two-Level Aperture Address Translator

This block turns addresses that fall inside a graphics aperture window into physical memory addresses. The upper part of an aperture address picks one of 64 on-chip directory slots. Each slot names a 4 KiB page of second-level entries held in ordinary memory. The block fetches the single 32-bit entry it needs from that page over a read request/response port. It then returns either a physical address or a fault.

Software fills the directory one slot at a time. Each write to a packed 32-bit load register carries the table-page base, the present flag and the slot number. A second register holds a 16-bit aperture-size code. A control register supplies a flush bit. An eight-entry direct-mapped cache holds recent translations so that repeated hits skip the memory fetch. Only one translation is in flight at any time. Requests and responses each use a valid/ready handshake.

Top module: `aper_xlate`

## Requirements
- R1: After reset every directory slot is not present, the size code is 0, the cache is empty, `req_ready` is 1 and neither `rsp_valid` nor `mem_req_valid` is asserted, so any first request faults without a memory read.
- R2: A write with `cfg_sel`=0 loads the directory. Slot number is bits 5:0, present flag is bit 8, and table-page base is bits 31:20. Bits 19:9 and 7:6 are ignored. A walk through a present slot reads the address {base, 8'h00, request bits 21:12, 2'b00}.
- R3: A load write with bit 8 clear makes that slot not present. A request that lands on a not-present slot faults and issues no memory read.
- R4: The slot number is request bits 31:22 minus `aper_base_blk`. A request whose bits 31:22 are below `aper_base_blk`, or whose difference is not below the slot limit of the current size, faults and issues no memory read.
- R5: A write with `cfg_sel`=1 loads the size code from bits 15:0. Code 0 allows 64 slots (256 MiB), 32 allows 32, 48 allows 16 and 56 allows 8. Any other code allows none, so every request faults.
- R6: A fetched entry with bit 0 set yields a physical address equal to entry bits 31:12 joined with request bits 11:0, with `rsp_fault`=0. An entry with bit 0 clear yields a fault.
- R7: Successful walks are cached in 8 direct-mapped sets indexed by the low 3 bits of the aperture page number (slot, bits 21:12). A repeat of a cached page needs no memory read. A page sharing the set evicts the earlier one.
- R8: A write with `cfg_sel`=2 whose bit 7 is 1 while the stored bit 7 is 0 empties the cache. The stored bit resets to 1, so writing 0x2280 while bit 7 is already set does not flush. Writing 0x2200 then 0x2280 does flush.
- R9: Every directory load write empties the cache.
- R10: Only one translation is in flight. `req_ready` is low from acceptance until the response handshake completes. `rsp_valid` with its data, and `mem_req_valid` with its address, are held until accepted.
- R11: If a flush occurs while a walk is in progress, that walk still returns its result but does not fill the cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 directory load, 1 size code, 2 control |
| cfg_wdata | input | 32 | Register write data |
| aper_base_blk | input | 10 | Aperture base address bits 31:22 |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_addr | input | 32 | Aperture bus address to translate |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer accepts the result |
| rsp_fault | output | 1 | Result is a fault |
| rsp_paddr | output | 32 | Translated physical address (0 on fault) |
| mem_req_valid | output | 1 | Second-level entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Second-level entry |

## Verification
The assertions assume a memory side that raises `mem_rsp_valid` for exactly one cycle per accepted read, and only after that read was accepted. They also assume that `aper_base_blk` does not change while a translation is pending. The bench memory model answers each accepted read once, after a chosen delay, and never answers spontaneously. The bench alters the base and the registers only between translations, except in the one directed case that flushes during a walk on purpose. Random addresses are drawn from a window slightly wider than the largest aperture, so below-base, in-range and over-limit cases all occur.

// File: rtl/aper_pkg.sv
package aper_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_MREQ,
    ST_MWAIT,
    ST_RESP
  } walk_state_e;

  typedef enum logic [1:0] {
    CFG_DIR  = 2'd0,
    CFG_SIZE = 2'd1,
    CFG_CTRL = 2'd2,
    CFG_NONE = 2'd3
  } cfg_sel_e;

  localparam logic [15:0] SZ_256M = 16'd0;
  localparam logic [15:0] SZ_128M = 16'd32;
  localparam logic [15:0] SZ_64M  = 16'd48;
  localparam logic [15:0] SZ_32M  = 16'd56;

  // Number of usable directory slots for a size code; unknown codes map nothing.
  function automatic logic [6:0] size_to_slots(input logic [15:0] code);
    logic [6:0] n;
    case (code)
      SZ_256M: n = 7'd64;
      SZ_128M: n = 7'd32;
      SZ_64M:  n = 7'd16;
      SZ_32M:  n = 7'd8;
      default: n = 7'd0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/aper_dir.sv
module aper_dir #(
  parameter int unsigned SLOTS   = 64,
  parameter int unsigned TBASE_W = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(SLOTS)-1:0]   wr_idx,
  input  logic                       wr_present,
  input  logic [TBASE_W-1:0]         wr_base,
  input  logic [$clog2(SLOTS)-1:0]   rd_idx,
  output logic                       rd_present,
  output logic [TBASE_W-1:0]         rd_base
);
  localparam int unsigned IDX_W = $clog2(SLOTS);

  logic [SLOTS-1:0]   present_q;
  logic [SLOTS-1:0]   present_d;
  logic [TBASE_W-1:0] base_q [SLOTS];

  always_comb begin
    present_d = present_q;
    if (wr_en) present_d[wr_idx] = wr_present;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) present_q <= '0;
    else        present_q <= present_d;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (sel) base_q[g] <= wr_base;
    end
  end

  assign rd_present = present_q[rd_idx];
  assign rd_base    = base_q[rd_idx];

  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (present_q[$past(wr_idx)] == $past(wr_present))); // R3

endmodule

// File: rtl/aper_tcache.sv
module aper_tcache #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned PAGE_W  = 16,
  parameter int unsigned FRAME_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [PAGE_W-1:0]  lk_page,
  output logic               lk_hit,
  output logic [FRAME_W-1:0] lk_frame,
  input  logic               fill_en,
  input  logic [PAGE_W-1:0]  fill_page,
  input  logic [FRAME_W-1:0] fill_frame
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned TAG_W = PAGE_W - IDX_W;

  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] valid_d;
  logic [TAG_W-1:0]   tag_q   [ENTRIES];
  logic [FRAME_W-1:0] frame_q [ENTRIES];

  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] fill_idx;
  logic             fill_ok;

  assign lk_idx   = lk_page[IDX_W-1:0];
  assign fill_idx = fill_page[IDX_W-1:0];
  assign fill_ok  = fill_en && !flush;

  assign lk_hit   = valid_q[lk_idx] && (tag_q[lk_idx] == lk_page[PAGE_W-1:IDX_W]);
  assign lk_frame = frame_q[lk_idx];

  always_comb begin
    valid_d = valid_q;
    if (flush)        valid_d = '0;
    else if (fill_en) valid_d[fill_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_set
    logic wr;
    assign wr = fill_ok && (fill_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (wr) begin
        tag_q[g]   <= fill_page[PAGE_W-1:IDX_W];
        frame_q[g] <= fill_frame;
      end
    end
  end

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0)); // R8

  AST_FILL_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush) |=> valid_q[$past(fill_idx)]); // R7

endmodule

// File: rtl/aper_walker.sv
module aper_walker
  import aper_pkg::*;
#(
  parameter int unsigned PA_W       = 32,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned L2_BITS    = 10,
  parameter int unsigned SLOTS      = 64,
  parameter int unsigned TBASE_W    = 12,
  localparam int unsigned SLOT_W    = $clog2(SLOTS),
  localparam int unsigned LIM_W     = SLOT_W + 1,
  localparam int unsigned DIR_SHIFT = PAGE_SHIFT + L2_BITS,
  localparam int unsigned HI_W      = PA_W - DIR_SHIFT,
  localparam int unsigned PAGE_W    = SLOT_W + L2_BITS,
  localparam int unsigned FRAME_W   = PA_W - PAGE_SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [PA_W-1:0]    req_addr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_fault,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [PA_W-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [PA_W-1:0]    mem_rsp_data,
  input  logic [HI_W-1:0]    base_blk,
  input  logic [LIM_W-1:0]   slot_limit,
  output logic [SLOT_W-1:0]  dir_idx,
  input  logic               dir_present,
  input  logic [TBASE_W-1:0] dir_base,
  output logic [PAGE_W-1:0]  lk_page,
  input  logic               lk_hit,
  input  logic [FRAME_W-1:0] lk_frame,
  output logic               fill_en,
  output logic [PAGE_W-1:0]  fill_page,
  output logic [FRAME_W-1:0] fill_frame,
  input  logic               flush
);
  localparam int unsigned GAP_W = PA_W - TBASE_W - L2_BITS - 2;

  walk_state_e         state_q, state_d;
  logic [PA_W-1:0]     req_q, req_d;
  logic [PAGE_W-1:0]   page_q, page_d;
  logic [PA_W-1:0]     maddr_q, maddr_d;
  logic [PA_W-1:0]     pa_q, pa_d;
  logic                fault_q, fault_d;
  logic                kill_q, kill_d;

  logic [HI_W-1:0]     hi;
  logic [HI_W-1:0]     diff;
  logic                in_rng;
  logic                unused_rsp_bits;

  assign hi      = req_q[PA_W-1:DIR_SHIFT];
  assign diff    = hi - base_blk;
  assign in_rng  = (hi >= base_blk) && (diff < HI_W'(slot_limit));
  assign dir_idx = diff[SLOT_W-1:0];
  assign lk_page = {dir_idx, req_q[DIR_SHIFT-1:PAGE_SHIFT]};
  assign unused_rsp_bits = ^mem_rsp_data[PAGE_SHIFT-1:1];

  always_comb begin
    state_d = state_q;
    req_d   = req_q;
    page_d  = page_q;
    maddr_d = maddr_q;
    pa_d    = pa_q;
    fault_d = fault_q;
    kill_d  = kill_q;
    fill_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          req_d   = req_addr;
          kill_d  = 1'b0;
          state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        page_d = lk_page;
        kill_d = flush;
        if (!in_rng || !dir_present) begin
          fault_d = 1'b1;
          pa_d    = '0;
          state_d = ST_RESP;
        end else if (lk_hit) begin
          fault_d = 1'b0;
          pa_d    = {lk_frame, req_q[PAGE_SHIFT-1:0]};
          state_d = ST_RESP;
        end else begin
          maddr_d = {dir_base, {GAP_W{1'b0}}, req_q[DIR_SHIFT-1:PAGE_SHIFT], 2'b00};
          state_d = ST_MREQ;
        end
      end
      ST_MREQ: begin
        if (flush) kill_d = 1'b1;
        if (mem_req_ready) state_d = ST_MWAIT;
      end
      ST_MWAIT: begin
        if (flush) kill_d = 1'b1;
        if (mem_rsp_valid) begin
          state_d = ST_RESP;
          if (mem_rsp_data[0]) begin
            fault_d = 1'b0;
            pa_d    = {mem_rsp_data[PA_W-1:PAGE_SHIFT], req_q[PAGE_SHIFT-1:0]};
            fill_en = !kill_q && !flush;
          end else begin
            fault_d = 1'b1;
            pa_d    = '0;
          end
        end
      end
      ST_RESP: begin
        if (rsp_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fault_q <= 1'b0;
      kill_q  <= 1'b0;
      pa_q    <= '0;
    end else begin
      state_q <= state_d;
      fault_q <= fault_d;
      kill_q  <= kill_d;
      pa_q    <= pa_d;
    end
  end

  always_ff @(posedge clk) begin
    req_q   <= req_d;
    page_q  <= page_d;
    maddr_q <= maddr_d;
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_fault     = fault_q;
  assign rsp_paddr     = pa_q;
  assign mem_req_valid = (state_q == ST_MREQ);
  assign mem_req_addr  = maddr_q;
  assign fill_page     = page_q;
  assign fill_frame    = mem_rsp_data[PA_W-1:PAGE_SHIFT];

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R10

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault))); // R10

  AST_OFFSET_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[PAGE_SHIFT-1:0] == req_q[PAGE_SHIFT-1:0])); // R6

  AST_RANGE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK && !in_rng) |=> (rsp_valid && rsp_fault && !mem_req_valid)); // R4

endmodule

// File: rtl/aper_xlate.sv
module aper_xlate
  import aper_pkg::*;
#(
  parameter int unsigned PA_W          = 32,
  parameter int unsigned PAGE_SHIFT    = 12,
  parameter int unsigned L2_BITS       = 10,
  parameter int unsigned SLOTS         = 64,
  parameter int unsigned CACHE_ENTRIES = 8,
  parameter int unsigned TBASE_W       = 12,
  parameter int unsigned SIZE_W        = 16,
  parameter int unsigned PRESENT_BIT   = 8,
  parameter int unsigned FLUSH_BIT     = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr_en,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic [9:0]  aper_base_blk,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic        rsp_fault,
  output logic [31:0] rsp_paddr,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data
);
  localparam int unsigned SLOT_W  = $clog2(SLOTS);
  localparam int unsigned LIM_W   = SLOT_W + 1;
  localparam int unsigned PAGE_W  = SLOT_W + L2_BITS;
  localparam int unsigned FRAME_W = PA_W - PAGE_SHIFT;

  logic [SIZE_W-1:0] size_q, size_d;
  logic              fbit_q, fbit_d;
  logic              dir_wr, size_wr, ctrl_wr;
  logic              flush;
  logic [LIM_W-1:0]  slot_limit;
  logic              unused_cfg_bits;

  logic [SLOT_W-1:0]  dir_idx;
  logic               dir_present;
  logic [TBASE_W-1:0] dir_base;
  logic [PAGE_W-1:0]  lk_page;
  logic               lk_hit;
  logic [FRAME_W-1:0] lk_frame;
  logic               fill_en;
  logic [PAGE_W-1:0]  fill_page;
  logic [FRAME_W-1:0] fill_frame;

  assign dir_wr  = cfg_wr_en && (cfg_sel == CFG_DIR);
  assign size_wr = cfg_wr_en && (cfg_sel == CFG_SIZE);
  assign ctrl_wr = cfg_wr_en && (cfg_sel == CFG_CTRL);

  always_comb begin
    size_d = size_q;
    fbit_d = fbit_q;
    if (size_wr) size_d = cfg_wdata[SIZE_W-1:0];
    if (ctrl_wr) fbit_d = cfg_wdata[FLUSH_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= '0;
      fbit_q <= 1'b1;
    end else begin
      size_q <= size_d;
      fbit_q <= fbit_d;
    end
  end

  assign flush      = dir_wr || (ctrl_wr && cfg_wdata[FLUSH_BIT] && !fbit_q);
  assign slot_limit = LIM_W'(size_to_slots(size_q));
  assign unused_cfg_bits = ^cfg_wdata[PA_W-TBASE_W-1:SIZE_W];

  aper_dir #(
    .SLOTS   (SLOTS),
    .TBASE_W (TBASE_W)
  ) u_dir (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (dir_wr),
    .wr_idx     (cfg_wdata[SLOT_W-1:0]),
    .wr_present (cfg_wdata[PRESENT_BIT]),
    .wr_base    (cfg_wdata[PA_W-1:PA_W-TBASE_W]),
    .rd_idx     (dir_idx),
    .rd_present (dir_present),
    .rd_base    (dir_base)
  );

  aper_tcache #(
    .ENTRIES (CACHE_ENTRIES),
    .PAGE_W  (PAGE_W),
    .FRAME_W (FRAME_W)
  ) u_cache (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .lk_page    (lk_page),
    .lk_hit     (lk_hit),
    .lk_frame   (lk_frame),
    .fill_en    (fill_en),
    .fill_page  (fill_page),
    .fill_frame (fill_frame)
  );

  aper_walker #(
    .PA_W       (PA_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .L2_BITS    (L2_BITS),
    .SLOTS      (SLOTS),
    .TBASE_W    (TBASE_W)
  ) u_walk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_fault     (rsp_fault),
    .rsp_paddr     (rsp_paddr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .base_blk      (aper_base_blk),
    .slot_limit    (slot_limit),
    .dir_idx       (dir_idx),
    .dir_present   (dir_present),
    .dir_base      (dir_base),
    .lk_page       (lk_page),
    .lk_hit        (lk_hit),
    .lk_frame      (lk_frame),
    .fill_en       (fill_en),
    .fill_page     (fill_page),
    .fill_frame    (fill_frame),
    .flush         (flush)
  );

  AST_UNKNOWN_SIZE_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_limit == '0) |-> !mem_req_valid || $past(slot_limit != '0)); // R5

endmodule

// File: tb/aper_xlate_bench.sv
module aper_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic [9:0]  aper_base_blk;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic        rsp_valid;
  logic        rsp_ready;
  logic        rsp_fault;
  logic [31:0] rsp_paddr;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  always #2 clk = ~clk;

  aper_xlate u_aper_xlate (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .aper_base_blk(aper_base_blk),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int checks = 0;
  int errors = 0;
  int mem_reads = 0;
  int mem_lat = 1;
  logic [19:0] salt = 20'h0;
  logic [31:0] last_maddr = 32'h0;

  logic        m_present [64];
  logic [11:0] m_base    [64];
  logic [15:0] m_size;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [19:0] fr;
    fr = a[31:12] ^ {a[11:2], a[11:2]} ^ salt;
    return {fr, 11'h0, ~(a[3] & a[2])};
  endfunction

  function automatic int slots_for(input logic [15:0] c);
    if (c == 16'd0)  return 64;
    if (c == 16'd32) return 32;
    if (c == 16'd48) return 16;
    if (c == 16'd56) return 8;
    return 0;
  endfunction

  task automatic predict(input logic [31:0] a, output logic f, output logic [31:0] pa,
                         output logic walk, output logic [31:0] maddr);
    logic [9:0] hi, diff;
    logic [5:0] idx;
    logic [31:0] w;
    hi = a[31:22];
    diff = hi - aper_base_blk;
    f = 1'b1; pa = 32'h0; walk = 1'b0; maddr = 32'h0;
    if (hi >= aper_base_blk && int'(diff) < slots_for(m_size)) begin
      idx = diff[5:0];
      if (m_present[idx]) begin
        walk = 1'b1;
        maddr = {m_base[idx], 8'h00, a[21:12], 2'b00};
        w = mem_word(maddr);
        if (w[0]) begin f = 1'b0; pa = {w[31:12], a[11:0]}; end
      end
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_sel = 2'd3;
    if (sel == 2'd0) begin
      m_present[d[5:0]] = d[8];
      m_base[d[5:0]] = d[31:20];
    end else if (sel == 2'd1) begin
      m_size = d[15:0];
    end
  endtask

  task automatic xlate(input logic [31:0] a, output logic f, output logic [31:0] pa,
                       output int rd);
    int r0;
    r0 = mem_reads;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    f = rsp_fault; pa = rsp_paddr;
    repeat ($urandom_range(0, 2)) @(negedge clk);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    rd = mem_reads - r0;
  endtask

  // Full check of one translation against the model; exp_rd < 0 skips the read count.
  task automatic xcheck(input string tag, input logic [31:0] a, input int exp_rd);
    logic ef, ew, f;
    logic [31:0] epa, em, pa;
    int rd;
    predict(a, ef, epa, ew, em);
    xlate(a, f, pa, rd);
    chk({tag, " fault"}, {31'h0, f}, {31'h0, ef});
    if (!ef) chk({tag, " paddr"}, pa, epa);
    if (exp_rd >= 0) chk({tag, " reads"}, rd, exp_rd);
    if (!ew) chk({tag, " no read on early fault"}, rd, 0);
    if (ew && rd == 1) chk({tag, " read addr"}, last_maddr, em);
  endtask

  // Memory responder: one response per accepted read.
  initial begin
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = 32'h0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        repeat (mem_lat) @(negedge clk);
        mem_req_ready = 1'b1;
        last_maddr = mem_req_addr;
        @(negedge clk);
        mem_req_ready = 1'b0;
        mem_reads++;
        repeat (mem_lat) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data = mem_word(last_maddr);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic f;
    logic [31:0] pa, pa_old;
    int rd;
    void'($urandom(32'd7));
    for (int i = 0; i < 64; i++) begin m_present[i] = 1'b0; m_base[i] = 12'h0; end
    m_size = 16'd0;
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_sel = 2'd3; cfg_wdata = 32'h0;
    aper_base_blk = 10'h100; req_valid = 1'b0; req_addr = 32'h0; rsp_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R1 req_ready", {31'h0, req_ready}, 32'h1);
    chk("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    chk("R1 mem_req_valid", {31'h0, mem_req_valid}, 32'h0);
    xcheck("R1 empty directory", 32'h4000_1234, 0);

    // R2: load all slots; ignored bits set to junk
    for (int i = 0; i < 64; i++)
      cfg_write(2'd0, {12'h800 + 12'(i), 8'hA5, 3'b111, 1'b1, 2'b11, 6'(i)});
    xcheck("R2 R6 first walk", 32'h4000_5678, 1);
    xcheck("R7 repeat hit", 32'h4000_5abc, 0);

    // R7/R8: stale data proves the hit; no-flush control write keeps it
    xlate(32'h4000_5010, f, pa_old, rd);
    salt = 20'h1F0F3;
    cfg_write(2'd2, 32'h0000_2280);
    xlate(32'h4000_5020, f, pa, rd);
    chk("R8 no flush when bit stays set reads", rd, 0);
    chk("R8 cached paddr kept", pa, {pa_old[31:12], 12'h020});
    cfg_write(2'd2, 32'h0000_2200);
    cfg_write(2'd2, 32'h0000_2280);
    xcheck("R8 flush forces walk", 32'h4000_5030, 1);

    // R7: set conflict
    xcheck("R7 other set", 32'h4000_6000, 1);
    xcheck("R7 conflicting page", 32'h4000_D000, 1);
    xcheck("R7 evicted page", 32'h4000_5000, 1);
    xcheck("R7 untouched set", 32'h4000_6004, 0);

    // R9: directory write flushes
    salt = 20'h2A2A2;
    cfg_write(2'd0, {12'h809, 8'h00, 3'b000, 1'b1, 2'b00, 6'd9});
    xcheck("R9 dir write flush", 32'h4000_5000, 1);

    // R3: invalidate slot 0
    cfg_write(2'd0, {26'h0, 6'd0});
    xcheck("R3 invalidated slot", 32'h4000_5000, 0);

    // R6: invalid second-level entry
    xcheck("R6 invalid entry", 32'h4040_3000, 1);

    // R4/R5: ranges per size code
    xcheck("R4 below base", 32'h3FC0_2000, 0);
    xcheck("R5 code0 last", 32'h4FC0_2000, -1);
    xcheck("R5 code0 over", 32'h5000_2000, 0);
    cfg_write(2'd1, 32'd32);
    xcheck("R5 code32 last", 32'h47C0_2000, -1);
    xcheck("R5 code32 over", 32'h4800_2000, 0);
    cfg_write(2'd1, 32'd48);
    xcheck("R5 code48 last", 32'h43C0_2000, -1);
    xcheck("R5 code48 over", 32'h4400_2000, 0);
    cfg_write(2'd1, 32'd56);
    xcheck("R5 code56 last", 32'h41C0_2000, -1);
    xcheck("R5 code56 over", 32'h4200_2000, 0);
    cfg_write(2'd1, 32'd5);
    xcheck("R5 unknown code", 32'h4080_2000, 0);
    cfg_write(2'd1, 32'd0);

    // R11 / R10: flush during a walk
    mem_lat = 8;
    fork
      xcheck("R11 walk under flush", 32'h4080_6000, 1);
      begin
        repeat (3) @(negedge clk);
        chk("R10 busy not ready", {31'h0, req_ready}, 32'h0);
        cfg_write(2'd2, 32'h0000_2200);
        cfg_write(2'd2, 32'h0000_2280);
      end
    join
    mem_lat = 1;
    xcheck("R11 not cached", 32'h4080_6000, 1);

    // Random phase
    for (int n = 0; n < 300; n++) begin
      int op;
      op = $urandom_range(0, 99);
      mem_lat = $urandom_range(0, 3);
      if (op < 10) begin
        logic [31:0] d;
        d = $urandom;
        d[8] = ($urandom_range(0, 3) != 0);
        cfg_write(2'd0, d);
      end else if (op < 15) begin
        int k;
        k = $urandom_range(0, 4);
        cfg_write(2'd1, (k == 0) ? 32'd0 : (k == 1) ? 32'd32 : (k == 2) ? 32'd48 :
                        (k == 3) ? 32'd56 : 32'd7);
      end else if (op < 20) begin
        cfg_write(2'd2, 32'h0000_2200);
        cfg_write(2'd2, 32'h0000_2280);
      end else begin
        logic [31:0] a;
        a = $urandom;
        a[31:22] = aper_base_blk - 10'd2 + 10'($urandom_range(0, 68));
        xcheck("R4 R6 random", a, -1);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule